// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the data path of a small 8-bit processor core: an arithmetic and logic unit that works on a registered accumulator and a second 8-bit operand. The second operand comes from a port that plays the role of a temporary register. A 4-bit operation code picks one of eleven operations: add, subtract, increment, decrement, compare, AND, OR, XOR, complement, rotate left and rotate right.

On a rising clock edge with `exec_i` high, the result goes back into the accumulator and the status flag byte is updated. Each operation class has its own rule for which flags it writes. Both registers drive the outputs directly. A 16-bit status word holds the accumulator in the high byte and the flags in the low byte.

Fetch, decode, decimal adjust and the register file sit outside this block.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous active-high `rst_i` clears the accumulator and the flag byte to 0x00 at the next rising edge.
- R2: With `exec_i` low, or with an operation code from 11 to 15, the accumulator and the flag byte keep their values.
- R3: Operation codes are 0 add, 1 subtract, 2 increment, 3 decrement, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement, 9 rotate left, 10 rotate right. Results are taken modulo 256. Add sets carry on a carry out of bit 7. Subtract sets carry when the operand is larger than the accumulator (a borrow).
- R4: The flag byte has sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2 and carry in bit 0. Bits 5, 3 and 1 always read 0.
- R5: Every operation except complement and the rotates sets the flags from its result: sign equals result bit 7, zero is set for a 0x00 result, and parity is set when the result has an even number of 1 bits.
- R6: Auxiliary carry is the carry out of bit 3 of the internal addition. For add this is A+B. For subtract and compare it is A+~B+1, so it is set when A[3:0] >= B[3:0]. For increment it is A+1, and for decrement it is A+0xFF, so it is set when A[3:0] is nonzero.
- R7: Compare writes every flag exactly as subtract would, and leaves the accumulator unchanged.
- R8: Increment and decrement write sign, zero, parity and auxiliary carry, and keep the carry flag.
- R9: AND, OR and XOR clear carry. AND sets auxiliary carry, and OR and XOR clear it.
- R10: Complement inverts the accumulator and changes no flag.
- R11: Rotate left moves bit 7 into bit 0 and into carry. Rotate right moves bit 0 into bit 7 and into carry. No other flag changes.
- R12: The new accumulator and flags appear on the outputs right after the executing edge. The status word always equals {accumulator, flags}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute the selected operation on this edge |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Second operand |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Status flag byte |
| status_o | output | 16 | Accumulator and flags combined |

## Verification
A wrong accumulator or flag bit is visible on `acc_o` and `flags_o` half a clock after the edge that wrote it, because both are plain registers. A flag-write rule that is wrong for one class shows up in two places: on the first operation of that class, or on the first later operation that reads the flag. For example, a rotate reads carry, and a compare that wrongly writes the accumulator shows up immediately. The reference model checks all three outputs every cycle under random opcodes, operands, idle cycles and resets, so a single-bit slip is caught within a cycle of its cause.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_W = 8;

  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_HALF = 4;
  localparam int FB_PAR  = 2;
  localparam int FB_CRY  = 0;

  localparam logic [7:0] FLAG_USED_MASK = 8'hD5;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_INC = 4'd2;
  localparam logic [3:0] OP_DEC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4;
  localparam logic [3:0] OP_AND = 4'd5;
  localparam logic [3:0] OP_OR  = 4'd6;
  localparam logic [3:0] OP_XOR = 4'd7;
  localparam logic [3:0] OP_CPL = 4'd8;
  localparam logic [3:0] OP_RLC = 4'd9;
  localparam logic [3:0] OP_RRC = 4'd10;

  typedef struct packed {
    logic wr_acc;
    logic upd_szp;
    logic upd_half;
    logic upd_cry;
    logic use_arith;
  } alu_ctl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import acc_alu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op_i,
  output alu_ctl_t        ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_ADD, OP_SUB: ctl_o = '{wr_acc: 1'b1, upd_szp: 1'b1, upd_half: 1'b1, upd_cry: 1'b1, use_arith: 1'b1};
      OP_INC, OP_DEC: ctl_o = '{wr_acc: 1'b1, upd_szp: 1'b1, upd_half: 1'b1, upd_cry: 1'b0, use_arith: 1'b1};
      OP_CMP:         ctl_o = '{wr_acc: 1'b0, upd_szp: 1'b1, upd_half: 1'b1, upd_cry: 1'b1, use_arith: 1'b1};
      OP_AND, OP_OR, OP_XOR:
                      ctl_o = '{wr_acc: 1'b1, upd_szp: 1'b1, upd_half: 1'b1, upd_cry: 1'b1, use_arith: 1'b0};
      OP_CPL:         ctl_o = '{wr_acc: 1'b1, upd_szp: 1'b0, upd_half: 1'b0, upd_cry: 1'b0, use_arith: 1'b0};
      OP_RLC, OP_RRC: ctl_o = '{wr_acc: 1'b1, upd_szp: 1'b0, upd_half: 1'b0, upd_cry: 1'b1, use_arith: 1'b0};
      default:        ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W    = 8,
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    res_o,
  output logic            cry_o,
  output logic            half_o
);

  localparam int H = W / 2;

  logic [W-1:0] addend;
  logic         cin;
  logic         is_sub;
  logic [W:0]   full_sum;
  logic [H:0]   low_sum;

  always_comb begin
    addend = b_i;
    cin    = 1'b0;
    is_sub = 1'b0;
    case (op_i)
      OP_SUB, OP_CMP: begin addend = ~b_i; cin = 1'b1; is_sub = 1'b1; end
      OP_INC:         begin addend = '0;   cin = 1'b1; end
      OP_DEC:         begin addend = '1;   cin = 1'b0; end
      default:        begin addend = b_i;  cin = 1'b0; end
    endcase
  end

  assign full_sum = {1'b0, a_i} + {1'b0, addend} + {{W{1'b0}}, cin};
  assign low_sum  = {1'b0, a_i[H-1:0]} + {1'b0, addend[H-1:0]} + {{H{1'b0}}, cin};

  assign res_o  = full_sum[W-1:0];
  assign cry_o  = is_sub ? ~full_sum[W] : full_sum[W];
  assign half_o = low_sum[H];

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W    = 8,
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    res_o,
  output logic            cry_o,
  output logic            half_o
);

  always_comb begin
    res_o  = a_i;
    cry_o  = 1'b0;
    half_o = 1'b0;
    case (op_i)
      OP_AND: begin res_o = a_i & b_i; half_o = 1'b1; end
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_RLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cry_o = a_i[W-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[W-1:1]};   cry_o = a_i[0]; end
      default: res_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_ctl_t          ctl_i,
  input  logic [W-1:0]      res_i,
  input  logic              half_i,
  input  logic              cry_i,
  input  logic [FLAG_W-1:0] old_i,
  output logic [FLAG_W-1:0] next_o
);

  always_comb begin
    next_o = old_i;
    if (ctl_i.upd_szp) begin
      next_o[FB_SIGN] = res_i[W-1];
      next_o[FB_ZERO] = (res_i == '0);
      next_o[FB_PAR]  = ~(^res_i);
    end
    if (ctl_i.upd_half) next_o[FB_HALF] = half_i;
    if (ctl_i.upd_cry)  next_o[FB_CRY]  = cry_i;
    next_o = next_o & FLAG_USED_MASK;
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W    = 8,
  parameter int OP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              exec_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      opnd_i,
  output logic [W-1:0]      acc_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [W+FLAG_W-1:0] status_o
);

  alu_ctl_t          ctl;
  logic [W-1:0]      acc_q;
  logic [FLAG_W-1:0] flag_q;
  logic [W-1:0]      ar_res, bo_res, res;
  logic              ar_cry, ar_half, bo_cry, bo_half;
  logic [FLAG_W-1:0] flag_next;

  alu_op_decode #(.OP_W(OP_W)) u_dec (.op_i(op_i), .ctl_o(ctl));

  alu_arith #(.W(W), .OP_W(OP_W)) u_arith (
    .op_i(op_i), .a_i(acc_q), .b_i(opnd_i),
    .res_o(ar_res), .cry_o(ar_cry), .half_o(ar_half)
  );

  alu_bitops #(.W(W), .OP_W(OP_W)) u_bitops (
    .op_i(op_i), .a_i(acc_q), .b_i(opnd_i),
    .res_o(bo_res), .cry_o(bo_cry), .half_o(bo_half)
  );

  assign res = ctl.use_arith ? ar_res : bo_res;

  alu_flag_merge #(.W(W)) u_flags (
    .ctl_i(ctl), .res_i(res),
    .half_i(ctl.use_arith ? ar_half : bo_half),
    .cry_i(ctl.use_arith ? ar_cry : bo_cry),
    .old_i(flag_q), .next_o(flag_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q  <= '0;
      flag_q <= '0;
    end else if (exec_i) begin
      if (ctl.wr_acc) acc_q <= res;
      flag_q <= flag_next;
    end
  end

  assign acc_o    = acc_q;
  assign flags_o  = flag_q;
  assign status_o = {acc_q, flag_q};

  // Reset clears both registers
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (acc_q == '0 && flag_q == '0));

  // Idle cycles hold state
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !exec_i |=> ($stable(acc_q) && $stable(flag_q)));

  // Sign and zero never both set (they always move together from one result)
  assert_sign_zero_excl_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !(flag_q[FB_SIGN] && flag_q[FB_ZERO]));

  // Compare keeps the accumulator
  assert_cmp_keeps_acc_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (exec_i && op_i == OP_CMP) |=> $stable(acc_q));

  // Increment/decrement keep carry
  assert_incdec_keep_cy_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (exec_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flag_q[FB_CRY] == $past(flag_q[FB_CRY])));

  // Logic operations clear carry
  assert_logic_clear_cy_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (exec_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=> !flag_q[FB_CRY]);

  // Complement inverts and leaves flags alone
  assert_cpl_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (exec_i && op_i == OP_CPL) |=> (acc_q == ~$past(acc_q) && $stable(flag_q)));

  // Rotate left: bit 7 to carry, other flags untouched
  assert_rlc_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (exec_i && op_i == OP_RLC) |=>
      (flag_q[FB_CRY] == $past(acc_q[W-1]) && flag_q[FLAG_W-1:1] == $past(flag_q[FLAG_W-1:1])));

  // Rotate right: bit 0 to carry, other flags untouched
  assert_rrc_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (exec_i && op_i == OP_RRC) |=>
      (flag_q[FB_CRY] == $past(acc_q[0]) && flag_q[FLAG_W-1:1] == $past(flag_q[FLAG_W-1:1])));

endmodule

// File: tb/acc_alu_core_bench.sv
`timescale 1ns/1ps
module acc_alu_core_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        exec;
  logic [3:0]  op;
  logic [7:0]  opnd;
  logic [7:0]  acc_o;
  logic [7:0]  flags_o;
  logic [15:0] status_o;

  int checks = 0;
  int errors = 0;
  int mA = 0;
  int mF = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu_core u_acc_alu_core (
    .clk_i(clk), .rst_i(rst), .exec_i(exec), .op_i(op), .opnd_i(opnd),
    .acc_o(acc_o), .flags_o(flags_o), .status_o(status_o)
  );

  function automatic int par_even(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string tag_of(input int r, input int e, input int o);
    if (r != 0) return "R1";
    if (e == 0 || o > 10) return "R2";
    case (o)
      0, 1: return "R3,R5,R6";
      2, 3: return "R8,R5,R6";
      4: return "R7";
      5, 6, 7: return "R9,R5";
      8: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Behavioural reference: R3..R11
  task automatic model(input int r, input int e, input int o, input int b);
    int a, res, s, z, ac, p, cy, wr, szp;
    if (r != 0) begin mA = 0; mF = 0; return; end
    if (e == 0 || o > 10) return;
    a = mA;
    s = (mF >> 7) & 1; z = (mF >> 6) & 1; ac = (mF >> 4) & 1;
    p = (mF >> 2) & 1; cy = mF & 1;
    wr = 1; szp = 1; res = a;
    case (o)
      0: begin res = a + b; cy = (res > 255); ac = ((a & 15) + (b & 15)) > 15; end
      1, 4: begin res = a - b; cy = (a < b); ac = ((a & 15) >= (b & 15)); wr = (o == 1); end
      2: begin res = a + 1; ac = ((a & 15) == 15); end
      3: begin res = a - 1; ac = ((a & 15) != 0); end
      5: begin res = a & b; cy = 0; ac = 1; end
      6: begin res = a | b; cy = 0; ac = 0; end
      7: begin res = a ^ b; cy = 0; ac = 0; end
      8: begin res = ~a; szp = 0; end
      9: begin res = (a << 1) | (a >> 7); cy = (a >> 7) & 1; szp = 0; end
      default: begin res = (a >> 1) | ((a & 1) << 7); cy = a & 1; szp = 0; end
    endcase
    res = res & 255;
    if (szp != 0) begin
      s = (res >> 7) & 1; z = (res == 0); p = par_even(res);
    end
    if (wr != 0) mA = res;
    mF = (s << 7) | (z << 6) | (ac << 4) | (p << 2) | cy;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int r, input int e, input int o, input int b);
    string t;
    rst = 1'(r); exec = 1'(e); op = 4'(o); opnd = 8'(b);
    @(posedge clk);
    model(r, e, o, b);
    @(negedge clk);
    t = tag_of(r, e, o);
    check(t, "acc", int'(acc_o), mA);
    check(t, "flags", int'(flags_o), mF);
    check("R4", "unused flag bits", int'(flags_o & 8'h2A), 0);
    check("R12", "status word", int'(status_o), (mA << 8) | mF);
  endtask

  initial begin
    rst = 1'b1; exec = 1'b0; op = '0; opnd = '0;
    @(negedge clk);
    step(1, 0, 0, 0);
    step(1, 1, 0, 8'h55);          // R1: reset wins over exec
    step(0, 1, 0, 8'h3A);          // add -> 3A
    step(0, 1, 0, 8'hC6);          // 3A+C6 = 00, Z,AC,P,CY (R3, R6)
    step(0, 1, 2, 0);              // inc 00 -> 01, carry kept (R8)
    step(0, 1, 1, 8'h07);          // 01-07 = FA, borrow (R3)
    step(0, 1, 4, 8'hFA);          // compare equal: Z, no borrow (R7)
    step(0, 1, 4, 8'hFF);          // compare with borrow, acc FA kept (R7)
    step(0, 1, 2, 0);              // FA -> FB, carry kept
    step(0, 1, 0, 8'h04);          // FB+04 = FF
    step(0, 1, 2, 0);              // FF -> 00, AC set, carry kept
    step(0, 1, 3, 0);              // 00 -> FF, AC clear
    step(0, 1, 5, 8'h0F);          // AND -> 0F, AC=1, CY=0 (R9)
    step(0, 1, 6, 8'h80);          // OR -> 8F (R9)
    step(0, 1, 7, 8'h8F);          // XOR -> 00 (R9)
    step(0, 1, 8, 0);              // CPL -> FF, flags same (R10)
    step(0, 1, 9, 0);              // RLC FF -> FF, CY=1 (R11)
    step(0, 1, 1, 8'h7F);          // FF-7F = 80
    step(0, 1, 9, 0);              // RLC 80 -> 01, CY=1
    step(0, 1, 10, 0);             // RRC 01 -> 80, CY=1
    step(0, 1, 10, 0);             // RRC 80 -> 40, CY=0
    step(0, 0, 0, 8'h11);          // exec low ignored (R2)
    step(0, 1, 12, 8'h11);         // undefined op ignored (R2)
    step(0, 1, 15, 8'h22);         // undefined op ignored (R2)
    for (int i = 0; i < 4000; i++)
      step(($urandom % 97) == 0, ($urandom % 5) != 0, $urandom % 16, $urandom % 256);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule